// File: doc/BRIEF.md
# Checkpointed Register Alias Table

This block is the rename map of an out-of-order core. Every architectural register has one entry, and each entry is in one of two states. It is either ready and holds a value, or it is pending and holds the tag of the instruction that will produce the value. At decode, source registers are looked up, so each operand comes back either as a usable value or as a tag to wait on. The destination of an accepted instruction is then re-pointed at the tag that instruction carries. Completed results are broadcast with their tag, and every pending entry whose tag matches becomes ready with the broadcast data.

The block also keeps one shadow copy of the whole map. The shadow is filled when a conditional branch is decoded. Results keep updating the live map and the shadow independently. If the branch turns out to be mispredicted, or an exception is raised while the shadow is held, the live map is replaced by the shadow in one cycle. Every mapping made after the branch is discarded. A branch that resolves as correct releases the shadow. Only one shadow exists, so a second branch is held back at decode until the first one resolves.

Decode is a valid/ready stream. An instruction is taken in a cycle where `dec_valid` and `dec_ready` are both high. `dec_ready` depends only on `dec_is_branch`, the resolve and exception inputs, and internal state, never on `dec_valid`. A source that sees `dec_ready` low must hold the instruction. Lookup outputs follow the `dec_src_*` inputs in every cycle, whatever the handshake. The result broadcast has no back-pressure and is taken whenever `res_valid` is high.

Top module: `ckpt_rename_table`

## Requirements
- R1: After reset every entry is ready with value 0. No checkpoint is held (`ckpt_held` low) and `dec_ready` is high.
- R2: An accepted non-branch decode with `dec_dst_en` high makes entry `dec_dst` pending with tag `dec_tag` from the next cycle. Lookups in the same cycle still see the earlier mapping.
- R3: A result (`res_valid` high) makes every pending entry whose tag equals `res_tag` ready with value `res_data` from the next cycle. Entries with a different tag, and entries already ready, are unchanged.
- R4: A lookup of a pending entry whose tag matches a result in the same cycle reports ready with `res_data` in that cycle.
- R5: When a decode writes a register in the same cycle as a result that matches that register's old tag, the entry ends pending on the new tag.
- R6: A branch decode (`dec_is_branch` high) is accepted only when no checkpoint is held. It copies the live map into the backup, including any result of the same cycle, sets `ckpt_held`, and writes no destination. While a checkpoint is held, `dec_ready` is low for branches and stays high for non-branches.
- R7: A result updates the backup by its own tag match, independently of the live map.
- R8: A mispredict (`br_resolve_valid` and `br_mispredict` high) or `exc_flush` while a checkpoint is held makes the live map equal the backup in the next cycle and clears `ckpt_held`. `dec_ready` is low in that cycle, so no decode is taken.
- R9: A restore in the same cycle as a result yields restored entries that already reflect that result when their backup tag matches.
- R10: A correct resolve (`br_resolve_valid` high, `br_mispredict` low) keeps the live map and clears `ckpt_held`. A branch decode is still stalled in that cycle and is accepted from the next cycle.
- R11: `br_resolve_valid` or `exc_flush` with no checkpoint held has no effect on the map.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decode instruction valid |
| dec_ready | output | 1 | Decode instruction accepted this cycle when valid |
| dec_is_branch | input | 1 | Instruction is a conditional branch |
| dec_dst_en | input | 1 | Instruction writes a destination register |
| dec_dst | input | IDX_W | Destination register index |
| dec_tag | input | TAG_W | Tag of the decoded instruction |
| dec_src_a | input | IDX_W | First source register index |
| dec_src_b | input | IDX_W | Second source register index |
| src_a_rdy | output | 1 | First source is ready |
| src_a_val | output | DATA_W | First source value (when ready) |
| src_a_tag | output | TAG_W | First source producer tag (when pending) |
| src_b_rdy | output | 1 | Second source is ready |
| src_b_val | output | DATA_W | Second source value (when ready) |
| src_b_tag | output | TAG_W | Second source producer tag (when pending) |
| res_valid | input | 1 | Result broadcast valid |
| res_tag | input | TAG_W | Tag of the completing instruction |
| res_data | input | DATA_W | Result value |
| br_resolve_valid | input | 1 | The outstanding branch resolves |
| br_mispredict | input | 1 | The resolving branch was mispredicted |
| exc_flush | input | 1 | Exception: restore to the checkpoint |
| ckpt_held | output | 1 | A checkpoint is held |

## Verification
Several functions can fall in one cycle, and the bench drives them together on purpose. A result can arrive in the same cycle as a restore, a branch capture or a destination write to the very entry it matches. A decode can be offered in the same cycle as a mispredict. A per-cycle model built from the requirements predicts the outcome of each such cycle. It is judged by the lookup outputs in that cycle (the bypass) and then by a sweep of every register through the lookup ports once the edge has passed. That sweep shows whether the restored, captured or rewritten entry carries the result, the new tag, or neither.

// File: rtl/rat_pkg.sv
package rat_pkg;

  typedef enum logic {
    CK_FREE = 1'b0,
    CK_HELD = 1'b1
  } ckpt_state_e;

  typedef enum logic [1:0] {
    NX_KEEP    = 2'd0,
    NX_RESTORE = 2'd1,
    NX_RELEASE = 2'd2,
    NX_CAPTURE = 2'd3
  } ckpt_event_e;

endpackage

// File: rtl/rat_wake.sv
module rat_wake #(
  parameter int DATA_W = 16,
  parameter int TAG_W  = 5
) (
  input  logic              in_rdy,
  input  logic [DATA_W-1:0] in_val,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic              res_valid,
  input  logic [TAG_W-1:0]  res_tag,
  input  logic [DATA_W-1:0] res_data,
  output logic              out_rdy,
  output logic [DATA_W-1:0] out_val,
  output logic [TAG_W-1:0]  out_tag
);

  logic hit;

  always_comb begin
    hit     = res_valid && !in_rdy && (in_tag == res_tag);
    out_rdy = in_rdy | hit;
    out_val = hit ? res_data : in_val;
    out_tag = in_tag;
  end

endmodule

// File: rtl/rat_ckpt_ctrl.sv
module rat_ckpt_ctrl
  import rat_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic dec_valid,
  input  logic dec_is_branch,
  input  logic br_resolve_valid,
  input  logic br_mispredict,
  input  logic exc_flush,
  output logic dec_ready,
  output logic restore,
  output logic capture,
  output logic held
);

  ckpt_state_e state_q;
  ckpt_event_e ev;

  always_comb begin
    held      = (state_q == CK_HELD);
    restore   = held && (exc_flush || (br_resolve_valid && br_mispredict));
    dec_ready = !restore && !(dec_is_branch && held);
    capture   = dec_valid && dec_ready && dec_is_branch;
    if (restore)
      ev = NX_RESTORE;
    else if (held && br_resolve_valid)
      ev = NX_RELEASE;
    else if (capture)
      ev = NX_CAPTURE;
    else
      ev = NX_KEEP;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= CK_FREE;
    end else begin
      case (ev)
        NX_RESTORE, NX_RELEASE: state_q <= CK_FREE;
        NX_CAPTURE:             state_q <= CK_HELD;
        default:                state_q <= state_q;
      endcase
    end
  end

endmodule

// File: rtl/rat_map_store.sv
module rat_map_store #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 16,
  parameter int TAG_W    = 5,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  input  logic [TAG_W-1:0]  res_tag,
  input  logic [DATA_W-1:0] res_data,
  input  logic              restore,
  input  logic              capture,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  output logic              cur_rdy [NUM_REGS],
  output logic [DATA_W-1:0] cur_val [NUM_REGS],
  output logic [TAG_W-1:0]  cur_tag [NUM_REGS]
);

  logic              bk_rdy [NUM_REGS];
  logic [DATA_W-1:0] bk_val [NUM_REGS];
  logic [TAG_W-1:0]  bk_tag [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_entry
    logic              cw_rdy, bw_rdy;
    logic [DATA_W-1:0] cw_val, bw_val;
    logic [TAG_W-1:0]  cw_tag, bw_tag;
    logic              sel_wr;

    rat_wake #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_cur_wake (
      .in_rdy(cur_rdy[g]), .in_val(cur_val[g]), .in_tag(cur_tag[g]),
      .res_valid(res_valid), .res_tag(res_tag), .res_data(res_data),
      .out_rdy(cw_rdy), .out_val(cw_val), .out_tag(cw_tag)
    );

    rat_wake #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_bk_wake (
      .in_rdy(bk_rdy[g]), .in_val(bk_val[g]), .in_tag(bk_tag[g]),
      .res_valid(res_valid), .res_tag(res_tag), .res_data(res_data),
      .out_rdy(bw_rdy), .out_val(bw_val), .out_tag(bw_tag)
    );

    assign sel_wr = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cur_rdy[g] <= 1'b1;
        cur_val[g] <= '0;
        cur_tag[g] <= '0;
      end else if (restore) begin
        cur_rdy[g] <= bw_rdy;
        cur_val[g] <= bw_val;
        cur_tag[g] <= bw_tag;
      end else if (sel_wr) begin
        cur_rdy[g] <= 1'b0;
        cur_val[g] <= cw_val;
        cur_tag[g] <= wr_tag;
      end else begin
        cur_rdy[g] <= cw_rdy;
        cur_val[g] <= cw_val;
        cur_tag[g] <= cw_tag;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bk_rdy[g] <= 1'b1;
        bk_val[g] <= '0;
        bk_tag[g] <= '0;
      end else if (capture) begin
        bk_rdy[g] <= cw_rdy;
        bk_val[g] <= cw_val;
        bk_tag[g] <= cw_tag;
      end else begin
        bk_rdy[g] <= bw_rdy;
        bk_val[g] <= bw_val;
        bk_tag[g] <= bw_tag;
      end
    end
  end

endmodule

// File: rtl/ckpt_rename_table.sv
module ckpt_rename_table #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 16,
  parameter int TAG_W    = 5,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dec_valid,
  output logic              dec_ready,
  input  logic              dec_is_branch,
  input  logic              dec_dst_en,
  input  logic [IDX_W-1:0]  dec_dst,
  input  logic [TAG_W-1:0]  dec_tag,
  input  logic [IDX_W-1:0]  dec_src_a,
  input  logic [IDX_W-1:0]  dec_src_b,
  output logic              src_a_rdy,
  output logic [DATA_W-1:0] src_a_val,
  output logic [TAG_W-1:0]  src_a_tag,
  output logic              src_b_rdy,
  output logic [DATA_W-1:0] src_b_val,
  output logic [TAG_W-1:0]  src_b_tag,
  input  logic              res_valid,
  input  logic [TAG_W-1:0]  res_tag,
  input  logic [DATA_W-1:0] res_data,
  input  logic              br_resolve_valid,
  input  logic              br_mispredict,
  input  logic              exc_flush,
  output logic              ckpt_held
);

  localparam int NUM_LK = 2;

  logic restore, capture, wr_en;
  logic              cur_rdy [NUM_REGS];
  logic [DATA_W-1:0] cur_val [NUM_REGS];
  logic [TAG_W-1:0]  cur_tag [NUM_REGS];

  logic [IDX_W-1:0]  lk_idx [NUM_LK];
  logic              lk_rdy [NUM_LK];
  logic [DATA_W-1:0] lk_val [NUM_LK];
  logic [TAG_W-1:0]  lk_tag [NUM_LK];

  rat_ckpt_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .dec_valid(dec_valid), .dec_is_branch(dec_is_branch),
    .br_resolve_valid(br_resolve_valid), .br_mispredict(br_mispredict),
    .exc_flush(exc_flush),
    .dec_ready(dec_ready), .restore(restore), .capture(capture),
    .held(ckpt_held)
  );

  assign wr_en = dec_valid && dec_ready && !dec_is_branch && dec_dst_en;

  rat_map_store #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .res_valid(res_valid), .res_tag(res_tag), .res_data(res_data),
    .restore(restore), .capture(capture),
    .wr_en(wr_en), .wr_idx(dec_dst), .wr_tag(dec_tag),
    .cur_rdy(cur_rdy), .cur_val(cur_val), .cur_tag(cur_tag)
  );

  assign lk_idx[0] = dec_src_a;
  assign lk_idx[1] = dec_src_b;

  for (genvar p = 0; p < NUM_LK; p++) begin : g_lookup
    rat_wake #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_lk_wake (
      .in_rdy(cur_rdy[lk_idx[p]]), .in_val(cur_val[lk_idx[p]]),
      .in_tag(cur_tag[lk_idx[p]]),
      .res_valid(res_valid), .res_tag(res_tag), .res_data(res_data),
      .out_rdy(lk_rdy[p]), .out_val(lk_val[p]), .out_tag(lk_tag[p])
    );
  end

  assign src_a_rdy = lk_rdy[0];
  assign src_a_val = lk_val[0];
  assign src_a_tag = lk_tag[0];
  assign src_b_rdy = lk_rdy[1];
  assign src_b_val = lk_val[1];
  assign src_b_tag = lk_tag[1];

endmodule

// File: rtl/ckpt_rename_table_chk.sv
module ckpt_rename_table_chk #(
  parameter int TAG_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dec_valid,
  input logic             dec_ready,
  input logic             dec_is_branch,
  input logic             res_valid,
  input logic [TAG_W-1:0] res_tag,
  input logic             src_a_rdy,
  input logic [TAG_W-1:0] src_a_tag,
  input logic             br_resolve_valid,
  input logic             br_mispredict,
  input logic             exc_flush,
  input logic             ckpt_held
);

  // R6
  branch_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ckpt_held && dec_is_branch) |-> !dec_ready);

  // R6
  ckpt_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_ready && dec_is_branch) |=> ckpt_held);

  // R6
  nonbranch_flow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ckpt_held && !dec_is_branch && !exc_flush && !br_resolve_valid) |-> dec_ready);

  // R8
  restore_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ckpt_held && (exc_flush || (br_resolve_valid && br_mispredict))) |-> !dec_ready);

  // R8
  restore_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ckpt_held && (exc_flush || (br_resolve_valid && br_mispredict))) |=> !ckpt_held);

  // R10
  release_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ckpt_held && br_resolve_valid && !br_mispredict) |=> !ckpt_held);

  // R11
  held_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ckpt_held && !br_resolve_valid && !exc_flush) |=> ckpt_held);

  // R4
  bypass_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !src_a_rdy) |-> (src_a_tag != res_tag));

endmodule

bind ckpt_rename_table ckpt_rename_table_chk #(.TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .dec_valid(dec_valid), .dec_ready(dec_ready), .dec_is_branch(dec_is_branch),
  .res_valid(res_valid), .res_tag(res_tag),
  .src_a_rdy(src_a_rdy), .src_a_tag(src_a_tag),
  .br_resolve_valid(br_resolve_valid), .br_mispredict(br_mispredict),
  .exc_flush(exc_flush), .ckpt_held(ckpt_held)
);

// File: tb/ckpt_rename_table_tb_top.sv
module ckpt_rename_table_tb_top;

  localparam int NR = 4;
  localparam int DW = 8;
  localparam int TW = 4;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dec_valid = 0, dec_is_branch = 0, dec_dst_en = 0;
  logic [IW-1:0] dec_dst = '0, dec_src_a = '0, dec_src_b = '0;
  logic [TW-1:0] dec_tag = '0, res_tag = '0;
  logic res_valid = 0, br_resolve_valid = 0, br_mispredict = 0, exc_flush = 0;
  logic [DW-1:0] res_data = '0;
  logic dec_ready, src_a_rdy, src_b_rdy, ckpt_held;
  logic [DW-1:0] src_a_val, src_b_val;
  logic [TW-1:0] src_a_tag, src_b_tag;

  int checks = 0;
  int failures = 0;

  bit          m_rdy [NR];
  int          m_val [NR];
  int          m_tag [NR];
  bit          b_rdy [NR];
  int          b_val [NR];
  int          b_tag [NR];
  bit          m_held;

  always #4 clk = ~clk;

  ckpt_rename_table #(.NUM_REGS(NR), .DATA_W(DW), .TAG_W(TW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .dec_valid(dec_valid), .dec_ready(dec_ready), .dec_is_branch(dec_is_branch),
    .dec_dst_en(dec_dst_en), .dec_dst(dec_dst), .dec_tag(dec_tag),
    .dec_src_a(dec_src_a), .dec_src_b(dec_src_b),
    .src_a_rdy(src_a_rdy), .src_a_val(src_a_val), .src_a_tag(src_a_tag),
    .src_b_rdy(src_b_rdy), .src_b_val(src_b_val), .src_b_tag(src_b_tag),
    .res_valid(res_valid), .res_tag(res_tag), .res_data(res_data),
    .br_resolve_valid(br_resolve_valid), .br_mispredict(br_mispredict),
    .exc_flush(exc_flush), .ckpt_held(ckpt_held)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Compare every register against the model through the lookup ports.
  task automatic sweep(string req);
    @(negedge clk);
    dec_valid = 0; res_valid = 0; br_resolve_valid = 0; exc_flush = 0;
    dec_is_branch = 0;
    for (int r = 0; r < NR; r += 2) begin
      dec_src_a = IW'(r);
      dec_src_b = IW'(r + 1);
      #1;
      chk(req, $sformatf("rdy[%0d]", r), int'(src_a_rdy), int'(m_rdy[r]));
      if (m_rdy[r]) chk(req, $sformatf("val[%0d]", r), int'(src_a_val), m_val[r]);
      else          chk(req, $sformatf("tag[%0d]", r), int'(src_a_tag), m_tag[r]);
      chk(req, $sformatf("rdy[%0d]", r + 1), int'(src_b_rdy), int'(m_rdy[r+1]));
      if (m_rdy[r+1]) chk(req, $sformatf("val[%0d]", r + 1), int'(src_b_val), m_val[r+1]);
      else            chk(req, $sformatf("tag[%0d]", r + 1), int'(src_b_tag), m_tag[r+1]);
    end
    chk(req, "ckpt_held", int'(ckpt_held), int'(m_held));
  endtask

  // One clock cycle with arbitrary inputs; checks handshake and lookup, then updates model.
  task automatic cyc(string req, bit dv, bit br, bit den, int dst, int tag,
                     bit rv, int rt, int rd, bit rsv, bit mis, bit exc, int sa);
    bit restore, rdy_exp, acc, lk_rdy;
    int lk_val;
    bit nr [NR]; int nv [NR]; int nt [NR];
    bit br_ [NR]; int bv [NR]; int bt [NR];
    @(negedge clk);
    dec_valid = dv; dec_is_branch = br; dec_dst_en = den;
    dec_dst = IW'(dst); dec_tag = TW'(tag);
    res_valid = rv; res_tag = TW'(rt); res_data = DW'(rd);
    br_resolve_valid = rsv; br_mispredict = mis; exc_flush = exc;
    dec_src_a = IW'(sa);
    #1;
    restore = m_held && (exc || (rsv && mis));
    rdy_exp = !restore && !(br && m_held);
    acc = dv && rdy_exp;
    chk(req, "dec_ready", int'(dec_ready), int'(rdy_exp));
    lk_rdy = m_rdy[sa] || (rv && m_tag[sa] == rt);
    lk_val = m_rdy[sa] ? m_val[sa] : rd;
    chk(req, "lookup rdy", int'(src_a_rdy), int'(lk_rdy));
    if (lk_rdy) chk(req, "lookup val", int'(src_a_val), lk_val);
    else        chk(req, "lookup tag", int'(src_a_tag), m_tag[sa]);
    for (int r = 0; r < NR; r++) begin
      nr[r] = m_rdy[r]; nv[r] = m_val[r]; nt[r] = m_tag[r];
      if (rv && !m_rdy[r] && m_tag[r] == rt) begin nr[r] = 1; nv[r] = rd; end
      br_[r] = b_rdy[r]; bv[r] = b_val[r]; bt[r] = b_tag[r];
      if (rv && !b_rdy[r] && b_tag[r] == rt) begin br_[r] = 1; bv[r] = rd; end
    end
    @(posedge clk);
    for (int r = 0; r < NR; r++) begin
      if (acc && br) begin b_rdy[r] = nr[r]; b_val[r] = nv[r]; b_tag[r] = nt[r]; end
      else begin b_rdy[r] = br_[r]; b_val[r] = bv[r]; b_tag[r] = bt[r]; end
      if (restore) begin m_rdy[r] = br_[r]; m_val[r] = bv[r]; m_tag[r] = bt[r]; end
      else if (acc && !br && den && r == dst) begin m_rdy[r] = 0; m_val[r] = nv[r]; m_tag[r] = tag; end
      else begin m_rdy[r] = nr[r]; m_val[r] = nv[r]; m_tag[r] = nt[r]; end
    end
    if (restore || (m_held && rsv)) m_held = 0;
    else if (acc && br) m_held = 1;
  endtask

  task automatic dec(string req, int dst, int tag);
    cyc(req, 1, 0, 1, dst, tag, 0, 0, 0, 0, 0, 0, dst);
  endtask

  task automatic res(string req, int tag, int data, int sa);
    cyc(req, 0, 0, 0, 0, 0, 1, tag, data, 0, 0, 0, sa);
  endtask

  task automatic branch(string req);
    cyc(req, 1, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int r = 0; r < NR; r++) begin
      m_rdy[r] = 1; m_val[r] = 0; m_tag[r] = 0;
      b_rdy[r] = 1; b_val[r] = 0; b_tag[r] = 0;
    end
    m_held = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1 reset state
    sweep("R1");
    chk("R1", "dec_ready", int'(dec_ready), 1);

    // R2 R3 R4: each register renamed then woken, bypass checked in the wake cycle
    for (int r = 0; r < NR; r++) begin
      dec("R2", r, r + 1);
      sweep("R2");
      res("R4", r + 1, 10 * r + 3, r);
      sweep("R3");
    end

    // R3 mismatching tag leaves entry pending
    dec("R3", 0, 5);
    res("R3", 6, 77, 0);
    sweep("R3");
    res("R3", 5, 55, 0);
    sweep("R3");

    // R5 decode and matching old-tag result in the same cycle
    dec("R5", 1, 7);
    cyc("R5", 1, 0, 1, 1, 8, 1, 7, 44, 0, 0, 0, 1);
    sweep("R5");
    res("R5", 8, 45, 1);

    // R3 sweep over all tags, two registers pending on the same tag
    for (int t = 0; t < 16; t++) begin
      dec("R3", t % NR, t);
      dec("R3", (t + 1) % NR, t);
      res("R3", t, (t * 13 + 1) % 256, t % NR);
      sweep("R3");
    end

    // R6 R7 R8 mispredict restore with older result landing in the backup
    dec("R7", 0, 2);
    branch("R6");
    sweep("R6");
    dec("R6", 1, 3);
    dec("R6", 0, 4);
    branch("R6");
    res("R7", 2, 99, 0);
    sweep("R7");
    cyc("R8", 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 0);
    sweep("R8");

    // R9 restore in the same cycle as a result, with a rejected decode
    dec("R9", 2, 9);
    branch("R9");
    dec("R9", 2, 10);
    cyc("R9", 1, 0, 1, 3, 11, 1, 9, 123, 1, 1, 0, 2);
    sweep("R9");

    // R10 correct resolve keeps younger mappings, new branch after release
    branch("R10");
    dec("R10", 3, 12);
    cyc("R10", 1, 1, 0, 0, 0, 0, 0, 0, 1, 0, 0, 3);
    sweep("R10");
    branch("R10");
    sweep("R10");
    cyc("R10", 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    res("R10", 12, 31, 3);
    sweep("R10");

    // R11 resolve or exception with no checkpoint
    dec("R11", 2, 6);
    cyc("R11", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    cyc("R11", 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 0);
    sweep("R11");
    res("R11", 6, 66, 2);

    // R8 exception restore
    branch("R8");
    dec("R8", 0, 13);
    cyc("R8", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    sweep("R8");

    // R6 capture includes a same-cycle result
    dec("R6", 1, 14);
    cyc("R6", 1, 1, 0, 0, 0, 1, 14, 88, 0, 0, 0, 1);
    dec("R6", 1, 15);
    cyc("R6", 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 1);
    sweep("R6");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule